// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block stands between the interrupt sources of a system and a processor core. It watches three request inputs: a reset request, a non-maskable request and a 6-bit maskable interrupt level. Each arriving event is latched into a pending register of its own. Once per instruction boundary, marked by a strobe from the core, the block looks at what is pending. It serves exactly one request per look, picking the most urgent.

A reset or non-maskable request raises a shared reset/NMI exception request. A maskable level is first written into the hardware-interrupt field of a cause register, which the core can read. The block raises the interrupt exception request only when the core's status word has its interrupt enable set and the level overlaps the status mask. A level that is masked stays pending and is looked at again at every later boundary. A level of zero withdraws the interrupt: its evaluation wipes the cause field and raises nothing. Exception requests stay high until the core acknowledges them, and the acknowledge retires the request that was served.

Top module: `irq_deliver_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both exception requests are low, `cause_hwint` is zero and nothing is pending.
- R2: Events on `rst_evt`, `nmi_evt` and `lvl_evt` each set their own pending state. One evaluation serves only the highest pending source, in the order reset, then non-maskable, then level.
- R3: A pending reset and a pending non-maskable request both raise `exc_rstnmi_req`. Acknowledging it retires only the source that was served, and the next pending source is served at a later strobe.
- R4: When a pending nonzero level is evaluated, `cause_hwint` takes the level value in the cycle after the strobe. `cause_upd` is high for that one cycle. This happens whether or not the interrupt is taken.
- R5: Evaluating a nonzero level raises `exc_int_req` exactly when `sr_ie` is 1 and the bitwise AND of the level and `sr_mask` is nonzero.
- R6: A level that is not taken stays pending. It is evaluated again at each following strobe and is taken once it is enabled and unmasked, with no new event needed.
- R7: A `lvl_evt` with `lvl_val` zero records a withdrawal. Its evaluation sets `cause_hwint` to zero, raises no request and drops the pending level.
- R8: A raised exception request stays high until `exc_ack`, and no evaluation happens while it is high. `exc_ack` has no effect while no request is raised.
- R9: Evaluation happens only in cycles where `insn_stb` is high. Pending events produce no output change without a strobe.
- R10: A later `lvl_evt` replaces the pending level value before it is evaluated.
- R11: `soft_clr` is a synchronous clear. It drops all pending state and both requests, and sets `cause_hwint` to zero in the next cycle. It takes precedence over events in the same cycle.
- R12: An event on the source being served that arrives while its request is held survives the acknowledge and is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous active-high clear of the block |
| rst_evt | input | 1 | Reset request event, one-cycle pulse |
| nmi_evt | input | 1 | Non-maskable request event, one-cycle pulse |
| lvl_evt | input | 1 | Maskable level event, one-cycle pulse |
| lvl_val | input | 6 | Level carried by `lvl_evt`, zero meaning withdrawal |
| insn_stb | input | 1 | Instruction boundary strobe, evaluation point |
| sr_ie | input | 1 | Status word current interrupt enable |
| sr_mask | input | 6 | Status word interrupt mask field |
| cause_hwint | output | 6 | Cause register hardware-interrupt field |
| cause_upd | output | 1 | One-cycle pulse after the cause field is written |
| exc_rstnmi_req | output | 1 | Reset/NMI exception request, held until acknowledge |
| exc_int_req | output | 1 | Interrupt exception request, held until acknowledge |
| exc_ack | input | 1 | Acknowledge of the raised exception request |

## Verification
The level path is swept over every nonzero level, every mask value and both enable states. The cause field must follow the level on each pass. The interrupt request must appear exactly for overlapping level and mask bits, which separates a correct AND-and-reduce from an OR or a missed bit position. Each pass that is not taken is then re-evaluated with the mask fully open, which separates a retained pending level from a dropped one. Directed sequences cover simultaneous events for priority, withdrawal after a masked level, latest-value replacement, strobe-less idling, acknowledge without a request, events during a held request, and the synchronous clear.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;
  typedef enum logic [1:0] {
    LV_IDLE  = 2'd0,
    LV_SET   = 2'd1,
    LV_WDRAW = 2'd2
  } lvl_st_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RST  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_LVL  = 2'd3
  } src_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_dlv_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             rst_evt,
  input  logic             nmi_evt,
  input  logic             lvl_evt,
  input  logic [LVL_W-1:0] lvl_val,
  input  logic             busy,
  input  logic             ack_acc,
  input  logic             clr_rst,
  input  logic             clr_nmi,
  input  logic             clr_lvl,
  output logic             pend_rst,
  output logic             pend_nmi,
  output lvl_st_e          lvl_st,
  output logic [LVL_W-1:0] lvl_q
);
  logic             pr_q, pr_d, pn_q, pn_d;
  logic             dr_q, dr_d, dn_q, dn_d, dl_q, dl_d;
  lvl_st_e          ls_q, ls_d;
  logic [LVL_W-1:0] lv_q, lv_d;
  logic             lv_en;

  always_comb begin
    pr_d  = pr_q;
    pn_d  = pn_q;
    ls_d  = ls_q;
    dr_d  = dr_q;
    dn_d  = dn_q;
    dl_d  = dl_q;
    lv_en = 1'b0;
    lv_d  = lvl_val;
    if (soft_clr) begin
      pr_d  = 1'b0;
      pn_d  = 1'b0;
      ls_d  = LV_IDLE;
      dr_d  = 1'b0;
      dn_d  = 1'b0;
      dl_d  = 1'b0;
      lv_en = 1'b1;
      lv_d  = '0;
    end else begin
      // a new event wins over a clear in the same cycle
      pr_d = rst_evt | (pr_q & ~(clr_rst & ~dr_q));
      pn_d = nmi_evt | (pn_q & ~(clr_nmi & ~dn_q));
      if (lvl_evt) begin
        lv_en = 1'b1;
        ls_d  = (lvl_val == '0) ? LV_WDRAW : LV_SET;
      end else if (clr_lvl && !dl_q) begin
        ls_d = LV_IDLE;
      end
      // remember events that arrive while a request is held
      dr_d = (dr_q | rst_evt) & busy & ~ack_acc;
      dn_d = (dn_q | nmi_evt) & busy & ~ack_acc;
      dl_d = (dl_q | lvl_evt) & busy & ~ack_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= 1'b0;
      pn_q <= 1'b0;
      ls_q <= LV_IDLE;
      dr_q <= 1'b0;
      dn_q <= 1'b0;
      dl_q <= 1'b0;
    end else begin
      pr_q <= pr_d;
      pn_q <= pn_d;
      ls_q <= ls_d;
      dr_q <= dr_d;
      dn_q <= dn_d;
      dl_q <= dl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lv_q <= '0;
    else if (lv_en) lv_q <= lv_d;
  end

  assign pend_rst = pr_q;
  assign pend_nmi = pn_q;
  assign lvl_st   = ls_q;
  assign lvl_q    = lv_q;

  // R10
  lvl_evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_evt && !soft_clr) |=> (ls_q != LV_IDLE && lv_q == $past(lvl_val)));

  // R2
  rst_evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !soft_clr) |=> pr_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_dlv_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             eval_en,
  input  logic             pend_rst,
  input  logic             pend_nmi,
  input  lvl_st_e          lvl_st,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic             sr_ie,
  input  logic [LVL_W-1:0] sr_mask,
  output src_e             pick,
  output logic             fire_int,
  output logic             lvl_wdraw,
  output logic [LVL_W-1:0] cause_val
);
  logic lvl_any;
  logic unmasked;

  assign lvl_any  = (lvl_st != LV_IDLE);
  assign unmasked = sr_ie && ((lvl_q & sr_mask) != '0);

  always_comb begin
    pick = SRC_NONE;
    if (eval_en) begin
      if (pend_rst)      pick = SRC_RST;
      else if (pend_nmi) pick = SRC_NMI;
      else if (lvl_any)  pick = SRC_LVL;
    end
  end

  assign fire_int  = (pick == SRC_LVL) && (lvl_st == LV_SET) && unmasked;
  assign lvl_wdraw = (pick == SRC_LVL) && (lvl_st == LV_WDRAW);
  assign cause_val = (lvl_st == LV_SET) ? lvl_q : '0;
endmodule

// File: rtl/irq_req_hold.sv
module irq_req_hold
  import irq_dlv_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  src_e             pick,
  input  logic             fire_int,
  input  logic             lvl_wdraw,
  input  logic [LVL_W-1:0] cause_val,
  input  logic             exc_ack,
  output logic             busy,
  output logic             ack_acc,
  output logic             clr_rst,
  output logic             clr_nmi,
  output logic             clr_lvl,
  output logic [LVL_W-1:0] cause_hwint,
  output logic             cause_upd,
  output logic             exc_rstnmi_req,
  output logic             exc_int_req
);
  logic             rn_q, rn_d, in_q, in_d, up_q, up_d;
  src_e             src_q, src_d;
  logic [LVL_W-1:0] cz_q, cz_d;
  logic             cz_en;

  assign busy    = rn_q | in_q;
  assign ack_acc = exc_ack & busy;
  assign clr_rst = ack_acc && (src_q == SRC_RST);
  assign clr_nmi = ack_acc && (src_q == SRC_NMI);
  assign clr_lvl = (ack_acc && (src_q == SRC_LVL)) || lvl_wdraw;

  always_comb begin
    rn_d  = rn_q;
    in_d  = in_q;
    src_d = src_q;
    up_d  = 1'b0;
    cz_en = 1'b0;
    cz_d  = cause_val;
    if (soft_clr) begin
      rn_d  = 1'b0;
      in_d  = 1'b0;
      src_d = SRC_NONE;
      cz_en = 1'b1;
      cz_d  = '0;
    end else if (ack_acc) begin
      rn_d  = 1'b0;
      in_d  = 1'b0;
      src_d = SRC_NONE;
    end else begin
      case (pick)
        SRC_RST, SRC_NMI: begin
          rn_d  = 1'b1;
          src_d = pick;
        end
        SRC_LVL: begin
          cz_en = 1'b1;
          up_d  = 1'b1;
          if (fire_int) begin
            in_d  = 1'b1;
            src_d = SRC_LVL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rn_q  <= 1'b0;
      in_q  <= 1'b0;
      up_q  <= 1'b0;
      src_q <= SRC_NONE;
    end else begin
      rn_q  <= rn_d;
      in_q  <= in_d;
      up_q  <= up_d;
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cz_q <= '0;
    else if (cz_en) cz_q <= cz_d;
  end

  assign cause_hwint    = cz_q;
  assign cause_upd      = up_q;
  assign exc_rstnmi_req = rn_q;
  assign exc_int_req    = in_q;

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rn_q, in_q}));

  // R8
  rstnmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_q && !exc_ack && !soft_clr) |=> rn_q);

  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && !exc_ack && !soft_clr) |=> (in_q && $stable(cz_q)));

  // R11
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!rn_q && !in_q && cz_q == '0));
endmodule

// File: rtl/irq_deliver_ctrl.sv
module irq_deliver_ctrl
  import irq_dlv_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             rst_evt,
  input  logic             nmi_evt,
  input  logic             lvl_evt,
  input  logic [LVL_W-1:0] lvl_val,
  input  logic             insn_stb,
  input  logic             sr_ie,
  input  logic [LVL_W-1:0] sr_mask,
  output logic [LVL_W-1:0] cause_hwint,
  output logic             cause_upd,
  output logic             exc_rstnmi_req,
  output logic             exc_int_req,
  input  logic             exc_ack
);
  logic             pend_rst, pend_nmi;
  lvl_st_e          lvl_st;
  logic [LVL_W-1:0] lvl_q, cause_val;
  logic             busy, ack_acc, clr_rst, clr_nmi, clr_lvl;
  logic             eval_en, fire_int, lvl_wdraw;
  src_e             pick;

  assign eval_en = insn_stb & ~busy & ~soft_clr;

  irq_pend_store #(.LVL_W(LVL_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .rst_evt  (rst_evt),
    .nmi_evt  (nmi_evt),
    .lvl_evt  (lvl_evt),
    .lvl_val  (lvl_val),
    .busy     (busy),
    .ack_acc  (ack_acc),
    .clr_rst  (clr_rst),
    .clr_nmi  (clr_nmi),
    .clr_lvl  (clr_lvl),
    .pend_rst (pend_rst),
    .pend_nmi (pend_nmi),
    .lvl_st   (lvl_st),
    .lvl_q    (lvl_q)
  );

  irq_arbiter #(.LVL_W(LVL_W)) u_arb (
    .eval_en   (eval_en),
    .pend_rst  (pend_rst),
    .pend_nmi  (pend_nmi),
    .lvl_st    (lvl_st),
    .lvl_q     (lvl_q),
    .sr_ie     (sr_ie),
    .sr_mask   (sr_mask),
    .pick      (pick),
    .fire_int  (fire_int),
    .lvl_wdraw (lvl_wdraw),
    .cause_val (cause_val)
  );

  irq_req_hold #(.LVL_W(LVL_W)) u_hold (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_clr       (soft_clr),
    .pick           (pick),
    .fire_int       (fire_int),
    .lvl_wdraw      (lvl_wdraw),
    .cause_val      (cause_val),
    .exc_ack        (exc_ack),
    .busy           (busy),
    .ack_acc        (ack_acc),
    .clr_rst        (clr_rst),
    .clr_nmi        (clr_nmi),
    .clr_lvl        (clr_lvl),
    .cause_hwint    (cause_hwint),
    .cause_upd      (cause_upd),
    .exc_rstnmi_req (exc_rstnmi_req),
    .exc_int_req    (exc_int_req)
  );

  // R9
  strobe_rstnmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_rstnmi_req) |-> $past(insn_stb));

  // R9
  strobe_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_upd |-> $past(insn_stb));

  // R5
  int_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_int_req) |-> ($past(sr_ie) && ((cause_hwint & $past(sr_mask)) != '0)));
endmodule

// File: tb/irq_deliver_ctrl_bench.sv
`timescale 1ns/1ps
module irq_deliver_ctrl_bench;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_clr = 1'b0, rst_evt = 1'b0, nmi_evt = 1'b0, lvl_evt = 1'b0;
  logic [LW-1:0] lvl_val = '0;
  logic          insn_stb = 1'b0, sr_ie = 1'b0, exc_ack = 1'b0;
  logic [LW-1:0] sr_mask = '0;
  logic [LW-1:0] cause_hwint;
  logic          cause_upd, exc_rstnmi_req, exc_int_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_deliver_ctrl #(.LVL_W(LW)) u_irq_deliver_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .rst_evt(rst_evt), .nmi_evt(nmi_evt), .lvl_evt(lvl_evt), .lvl_val(lvl_val),
    .insn_stb(insn_stb), .sr_ie(sr_ie), .sr_mask(sr_mask),
    .cause_hwint(cause_hwint), .cause_upd(cause_upd),
    .exc_rstnmi_req(exc_rstnmi_req), .exc_int_req(exc_int_req), .exc_ack(exc_ack)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input int rn, input int ir, input int cz);
    chk({tag, " rstnmi"}, int'(exc_rstnmi_req), rn);
    chk({tag, " int"}, int'(exc_int_req), ir);
    chk({tag, " cause"}, int'(cause_hwint), cz);
  endtask

  task automatic lvl(input int v);
    lvl_evt = 1'b1; lvl_val = LW'(v); step(); lvl_evt = 1'b0;
  endtask

  task automatic stb();
    insn_stb = 1'b1; step(); insn_stb = 1'b0;
  endtask

  task automatic ack();
    exc_ack = 1'b1; step(); exc_ack = 1'b0;
  endtask

  task automatic sclr();
    soft_clr = 1'b1; step(); soft_clr = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    outs("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    step();
    outs("R1 after release", 0, 0, 0);
    stb();
    outs("R1 nothing pending", 0, 0, 0);

    // R2 R3 R9: simultaneous events, no strobe, then priority
    sr_ie = 1'b1; sr_mask = 6'h3F;
    rst_evt = 1'b1; nmi_evt = 1'b1; lvl_evt = 1'b1; lvl_val = 6'd9;
    step();
    rst_evt = 1'b0; nmi_evt = 1'b0; lvl_evt = 1'b0;
    repeat (4) step();
    outs("R9 idle without strobe", 0, 0, 0);
    chk("R9 no cause_upd", int'(cause_upd), 0);
    stb();
    outs("R2 reset first", 1, 0, 0);
    stb();
    outs("R8 no eval while held", 1, 0, 0);
    ack();
    outs("R3 ack drops", 0, 0, 0);
    stb();
    outs("R3 nmi next", 1, 0, 0);
    ack();
    stb();
    outs("R2 level last", 0, 1, 9);
    ack();
    stb();
    outs("R3 all retired", 0, 0, 9);
    ack();
    outs("R8 ack without request", 0, 0, 9);

    // R7 withdrawal after a masked level
    sclr();
    outs("R11 clear cause", 0, 0, 0);
    sr_mask = 6'h00;
    lvl(5);
    stb();
    outs("R7 masked stored", 0, 0, 5);
    lvl(0);
    stb();
    outs("R7 withdraw wipes", 0, 0, 0);
    chk("R7 upd on withdraw", int'(cause_upd), 1);
    sr_mask = 6'h3F;
    stb();
    outs("R7 pending dropped", 0, 0, 0);

    // R10 latest level wins
    sr_mask = 6'h04;
    lvl(1);
    lvl(4);
    stb();
    outs("R10 replaced", 0, 1, 4);
    // R12 new level while held survives ack
    lvl(2);
    ack();
    outs("R12 ack", 0, 0, 4);
    sr_mask = 6'h02;
    stb();
    outs("R12 redelivered", 0, 1, 2);
    ack();

    // R12 reset event during held reset request
    rst_evt = 1'b1; step(); rst_evt = 1'b0;
    stb();
    rst_evt = 1'b1; step(); rst_evt = 1'b0;
    ack();
    stb();
    outs("R12 reset again", 1, 0, 2);
    ack();
    stb();
    outs("R12 then idle", 0, 0, 2);

    // R11 clear with held request and pending work
    nmi_evt = 1'b1; step(); nmi_evt = 1'b0;
    stb();
    rst_evt = 1'b1; lvl_evt = 1'b1; lvl_val = 6'd3; step();
    rst_evt = 1'b0; lvl_evt = 1'b0;
    soft_clr = 1'b1; nmi_evt = 1'b1; step(); soft_clr = 1'b0; nmi_evt = 1'b0;
    outs("R11 requests dropped", 0, 0, 0);
    stb();
    outs("R11 pending dropped", 0, 0, 0);

    // R4 R5 R6 sweep over level, mask and enable
    for (int ie = 0; ie < 2; ie++) begin
      for (int m = 0; m < 64; m++) begin
        for (int l = 1; l < 64; l++) begin
          bit exp_t;
          exp_t = (ie == 1) && ((l & m) != 0);
          sclr();
          lvl(l);
          sr_ie = ie[0]; sr_mask = LW'(m);
          stb();
          chk("R4 cause", int'(cause_hwint), l);
          chk("R4 upd", int'(cause_upd), 1);
          chk("R5 int", int'(exc_int_req), int'(exp_t));
          chk("R5 rstnmi", int'(exc_rstnmi_req), 0);
          if (!exp_t) begin
            sr_ie = 1'b1; sr_mask = 6'h3F;
            stb();
            chk("R6 retaken", int'(exc_int_req), 1);
          end
          ack();
          chk("R8 ack clears", int'(exc_int_req), 0);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule